// File: doc/BRIEF.md
# Windowed Key-Serviced Watchdog

This block is a watchdog timer. It asks for a system reset when software stops running in the order it should. It comes out of reset disabled. Software arms it by writing a nonzero period code to its control register. From then on, software must write a two-byte key to the service register before the chosen period runs out. If the key does not arrive in time, the block raises a reset request. A wrong key value also raises a reset request. With the window option on, a key write that comes too early in the period raises one as well.

The counter advances on a qualified clock enable taken from the watchdog input clock. In the low-power stop mode the counter freezes, unless the stop-continue input is high. The parameter `SCALE_SHIFT` shortens every period by a power of two. This lets every period code be exercised in a short run.

A four-state machine controls the block:
- `ST_OFF`: the watchdog is disabled and the counter is held at zero.
- `ST_WAIT_KEY1`: the watchdog is armed and waiting for the first key byte.
- `ST_WAIT_KEY2`: the first key byte has arrived and the second is awaited.
- `ST_TRIP`: the reset-request cycle.

The transitions are as follows:
- arm: `ST_OFF` to `ST_WAIT_KEY1`.
- first key: `ST_WAIT_KEY1` to `ST_WAIT_KEY2`.
- second key, which restarts the count: `ST_WAIT_KEY2` to `ST_WAIT_KEY1`.
- bad write or expiry: any armed state to `ST_TRIP`.
- release: `ST_TRIP` to `ST_OFF`.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is disabled and `rst_req` is low. While it is disabled, service-register writes of any value have no effect.
- R2: The control field `ctl_wdata[2:0]` selects the period. Codes 1 to 7 give 2^(E-SCALE_SHIFT) clock cycles, with E equal to 14, 16, 18, 20, 22, 23 and 24 respectively. Without service, `rst_req` rises exactly that many cycles after the clock edge that took the arming write.
- R3: Writing 0x55 and then 0xAA to the service register restarts the period count from zero at the edge that takes the 0xAA.
- R4: A service write of any value other than 0x55 or 0xAA, while the watchdog is armed, makes `rst_req` high in the cycle after that write.
- R5: A 0xAA write that does not directly follow 0x55 does not restart the count. The machine keeps waiting for 0x55.
- R6: The window option is `ctl_wdata[3]`. With it set, a service write taken while the count is below three quarters of the period raises `rst_req` in the next cycle. A write taken when the count equals exactly three quarters of the period is accepted.
- R7: `rst_req` is high for exactly one cycle. After that cycle the control register reads back as disabled, so no further time-out occurs until software arms the watchdog again.
- R8: Control writes are accepted only while the watchdog is disabled. While it is armed they have no effect on the period or on the window setting.
- R9: While `stop_mode` is high and `stop_run_en` is low, the count holds. When `stop_run_en` is high, the count keeps advancing in stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | [2:0] period code, [3] window enable |
| svc_wr | input | 1 | Service register write strobe |
| svc_wdata | input | 8 | Service key byte |
| stop_mode | input | 1 | Low-power stop mode active |
| stop_run_en | input | 1 | Keep counting during stop mode |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench looks first at the exact expiry edge of every period code. If a design is off by one cycle or decodes an exponent wrongly, `rst_req` rises a cycle early or late, or it rises at another period altogether.

The window boundary is probed one count below three quarters of the period and again exactly at it. A design with the comparison off by one either trips on a legal write or accepts an early one.

A stray 0xAA, a control rewrite while armed, and stop mode with counting disabled are each followed by a check of when the reset request fires. A design that wrongly restarts, reloads or keeps counting fires too early or too late. After every pulse, a quiet stretch longer than the period shows whether the control register really went back to disabled.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT_KEY1,
        ST_WAIT_KEY2,
        ST_TRIP
    } wd_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam int         MAX_EXP    = 24;

    // log2 of the period for a nonzero rate code
    function automatic int rate_exp(input logic [2:0] code);
        if (code == 3'd0)
            return 0;
        else if (code <= 3'd5)
            return 12 + 2 * int'(code);
        else
            return 17 + int'(code);
    endfunction

endpackage

// File: rtl/wdog_period_sel.sv
module wdog_period_sel
    import keyed_wdog_pkg::*;
#(
    parameter int SHIFT = 0,
    parameter int LIM_W = MAX_EXP - SHIFT + 1
) (
    input  logic [2:0]       rate,
    output logic [LIM_W-1:0] limit,
    output logic [LIM_W-1:0] win_start
);

    logic [LIM_W-1:0] lim_tab [0:7];

    for (genvar g = 0; g < 8; g++) begin : g_rate
        if (g == 0) begin : g_off
            assign lim_tab[g] = '0;
        end else begin : g_on
            localparam int EXP_G = rate_exp(3'(g)) - SHIFT;
            assign lim_tab[g] = LIM_W'(1) << EXP_G;
        end
    end

    assign limit     = lim_tab[rate];
    assign win_start = limit - (limit >> 2);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int LIM_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [LIM_W-1:0] limit,
    output logic [LIM_W-1:0] cnt,
    output logic             expire
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en)
            cnt <= cnt + LIM_W'(1);
    end

    assign expire = en && (cnt == limit - LIM_W'(1));

    p_hold_when_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt))
        else $error("count moved while gated");

    p_within_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < limit))
        else $error("count passed the period");

endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
    import keyed_wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    input  logic       win_en,
    input  logic       win_open,
    input  logic       expire,
    output wd_state_e  state,
    output logic       armed,
    output logic       cnt_clr,
    output logic       rst_req
);

    wd_state_e state_nx;
    logic      key_ok;
    logic      bad_wr;
    logic      restart;

    assign key_ok  = (svc_data == KEY_FIRST) || (svc_data == KEY_SECOND);
    assign bad_wr  = armed && svc_wr && (!key_ok || (win_en && !win_open));
    assign restart = (state == ST_WAIT_KEY2) && svc_wr && !bad_wr
                     && (svc_data == KEY_SECOND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (arm)
                    state_nx = ST_WAIT_KEY1;
            end
            ST_WAIT_KEY1: begin
                if (bad_wr || expire)
                    state_nx = ST_TRIP;
                else if (svc_wr && svc_data == KEY_FIRST)
                    state_nx = ST_WAIT_KEY2;
            end
            ST_WAIT_KEY2: begin
                if (bad_wr)
                    state_nx = ST_TRIP;
                else if (restart)
                    state_nx = ST_WAIT_KEY1;
                else if (expire)
                    state_nx = ST_TRIP;
            end
            ST_TRIP: state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        armed   = (state == ST_WAIT_KEY1) || (state == ST_WAIT_KEY2);
        rst_req = (state == ST_TRIP);
        cnt_clr = !armed || restart;
    end

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req)
        else $error("reset request longer than one cycle");

    p_bad_key_trips_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && svc_wr && svc_data != 8'h55 && svc_data != 8'hAA) |=> rst_req)
        else $error("bad key did not trip");

    p_early_write_trips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && svc_wr && win_en && !win_open) |=> rst_req)
        else $error("early write did not trip");

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import keyed_wdog_pkg::*;
#(
    parameter int SCALE_SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [3:0] ctl_wdata,
    input  logic       svc_wr,
    input  logic [7:0] svc_wdata,
    input  logic       stop_mode,
    input  logic       stop_run_en,
    output logic       rst_req
);

    localparam int LIM_W = MAX_EXP - SCALE_SHIFT + 1;

    logic [2:0]       rate_q;
    logic             win_q;
    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] win_start;
    logic [LIM_W-1:0] cnt;
    logic             expire;
    logic             armed;
    logic             cnt_clr;
    logic             clk_on;
    logic             st_off;
    logic             arm;
    wd_state_e        state;

    assign st_off = (state == ST_OFF);
    assign arm    = ctl_wr && st_off && (ctl_wdata[2:0] != 3'd0);
    assign clk_on = !stop_mode || stop_run_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= 3'd0;
            win_q  <= 1'b0;
        end else if (rst_req) begin
            rate_q <= 3'd0;
            win_q  <= 1'b0;
        end else if (ctl_wr && st_off) begin
            rate_q <= ctl_wdata[2:0];
            win_q  <= ctl_wdata[3];
        end
    end

    wdog_period_sel #(.SHIFT(SCALE_SHIFT), .LIM_W(LIM_W)) u_period (
        .rate      (rate_q),
        .limit     (limit),
        .win_start (win_start)
    );

    wdog_counter #(.LIM_W(LIM_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .en     (armed && clk_on),
        .limit  (limit),
        .cnt    (cnt),
        .expire (expire)
    );

    wdog_key_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .svc_wr   (svc_wr),
        .svc_data (svc_wdata),
        .win_en   (win_q),
        .win_open (cnt >= win_start),
        .expire   (expire),
        .state    (state),
        .armed    (armed),
        .cnt_clr  (cnt_clr),
        .rst_req  (rst_req)
    );

    p_ctl_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (rate_q == 3'd0 && !win_q))
        else $error("control not cleared after reset request");

    p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ctl_wr) |=> ($stable(rate_q) && $stable(win_q)))
        else $error("control changed while armed");

endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;

    localparam int SHIFT = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [3:0] ctl_wdata = '0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_wdata = '0;
    logic       stop_mode = 1'b0;
    logic       stop_run_en = 1'b0;
    logic       rst_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    keyed_watchdog #(.SCALE_SHIFT(SHIFT)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .svc_wr(svc_wr), .svc_wdata(svc_wdata), .stop_mode(stop_mode),
        .stop_run_en(stop_run_en), .rst_req(rst_req)
    );

    function automatic int period(input int code);
        int e;
        case (code)
            1: e = 14;
            2: e = 16;
            3: e = 18;
            4: e = 20;
            5: e = 22;
            6: e = 23;
            7: e = 24;
            default: e = SHIFT;
        endcase
        return 1 << (e - SHIFT);
    endfunction

    task automatic expect_req(input string tag, input logic exp);
        n_tests++;
        if (rst_req !== exp) begin
            n_fail++;
            $display("FAIL %s: rst_req=%0b expected %0b", tag, rst_req, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_ctl(input logic [3:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic put_svc(input logic [7:0] v);
        svc_wr = 1'b1; svc_wdata = v;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    // count c cycles into a period of length len: expect the pulse at len
    task automatic trip_after(input string tag, input int len, input int c);
        step(len - c - 1);
        expect_req({tag, " before expiry"}, 1'b0);
        step(1);
        expect_req({tag, " at expiry"}, 1'b1);
        step(1);
        expect_req({tag, " pulse ends"}, 1'b0);
    endtask

    task automatic t_reset_r1;
        expect_req("R1 reset state", 1'b0);
        put_svc(8'h33);
        expect_req("R1 bad key while off", 1'b0);
        put_svc(8'h55);
        put_svc(8'hAA);
        step(40);
        expect_req("R1 idle stays quiet", 1'b0);
    endtask

    task automatic t_periods_r2;
        for (int code = 1; code < 8; code++) begin
            put_ctl(4'(code));
            trip_after($sformatf("R2 code %0d", code), period(code), 0);
        end
    endtask

    task automatic t_service_r3;
        put_ctl(4'd1);
        step(5);
        put_svc(8'h55);
        put_svc(8'hAA);
        trip_after("R3 restart", period(1), 0);
    endtask

    task automatic t_badkey_r4;
        put_ctl(4'd1);
        step(4);
        put_svc(8'h12);
        expect_req("R4 bad key in first state", 1'b1);
        step(1);
        put_ctl(4'd1);
        put_svc(8'h55);
        put_svc(8'h00);
        expect_req("R4 bad key in second state", 1'b1);
        step(1);
    endtask

    task automatic t_stray_r5;
        put_ctl(4'd1);
        step(3);
        put_svc(8'hAA);
        expect_req("R5 stray second key", 1'b0);
        trip_after("R5 no restart", period(1), 4);
    endtask

    task automatic t_window_r6;
        put_ctl(4'b1001);
        step(11);
        put_svc(8'h55);
        expect_req("R6 early write trips", 1'b1);
        step(1);
        put_ctl(4'b1001);
        step(12);
        put_svc(8'h55);
        expect_req("R6 write at boundary", 1'b0);
        put_svc(8'hAA);
        expect_req("R6 second key in window", 1'b0);
        trip_after("R6 restart in window", period(1), 0);
    endtask

    task automatic t_pulse_r7;
        put_ctl(4'd1);
        trip_after("R7 pulse width", period(1), 0);
        step(40);
        expect_req("R7 disabled after pulse", 1'b0);
    endtask

    task automatic t_lock_r8;
        put_ctl(4'd1);
        step(2);
        put_ctl(4'b1111);
        expect_req("R8 rewrite while armed", 1'b0);
        trip_after("R8 period kept", period(1), 3);
    endtask

    task automatic t_gate_r9;
        put_ctl(4'd1);
        stop_mode = 1'b1;
        stop_run_en = 1'b0;
        step(50);
        expect_req("R9 frozen in stop", 1'b0);
        stop_run_en = 1'b1;
        trip_after("R9 running in stop", period(1), 0);
        stop_mode = 1'b0;
        stop_run_en = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset_r1();
        t_periods_r2();
        t_service_r3();
        t_badkey_r4();
        t_stray_r5();
        t_window_r6();
        t_pulse_r7();
        t_lock_r8();
        t_gate_r9();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule